// File: doc/BRIEF.md
# Register-Memory Arithmetic and Logic Unit

This unit is the execute stage of a small four-register processor that works in the accumulator style. Each cycle it takes a 6-bit operation code, the value of one register, and a second operand. Outside logic fetches that second operand either from a data-memory word or from an immediate field. The unit computes an 8-bit result, a zero flag for later conditional branches, and a write-enable. The write-enable tells the surrounding datapath whether the result should replace the destination register.

The unit covers:

- add, subtract and multiply, all wrapping at 8 bits;
- divide and remainder, with a defined answer for a zero divisor;
- bitwise AND, OR, XOR and NOT;
- shifts and rotates by one bit position;
- compare, which only changes the flag.

Each arithmetic operation has a memory form and an immediate form. Both forms behave the same, because operand selection happens upstream. The register value is always the left-hand operand.

All outputs are registered. A result appears one clock after its inputs were sampled. Operand fetch, register writeback and memory access live outside this unit.

Top module: `rmalu`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `res_o`=0, `zero_o`=0 and `wen_o`=0.
- R2: Codes 7 (memory form) and 8 (immediate form) give `(reg_i + opnd_i) mod 256`.
- R3: Codes 10 and 11 give `(reg_i - opnd_i) mod 256`.
- R4: Codes 12 and 13 give the low 8 bits of `reg_i * opnd_i`.
- R5: Codes 14 and 15 give `reg_i / opnd_i`, truncated. Codes 16 and 17 give `reg_i mod opnd_i`. Both apply when `opnd_i` is nonzero.
- R6: When `opnd_i` is 0, codes 14 and 15 give 0xFF, and codes 16 and 17 give `reg_i`.
- R7: Codes 21, 22 and 23 give AND, OR and XOR of `reg_i` with `opnd_i`. Code 24 gives the complement of `reg_i` and ignores `opnd_i`.
- R8: The following codes move `reg_i` by one bit and ignore `opnd_i`:
  - code 25 shifts left, with bit 0 filled by 0;
  - code 26 shifts right, with bit 7 filled by 0;
  - code 27 rotates left, so old bit 7 lands in bit 0;
  - code 28 rotates right, so old bit 0 lands in bit 7.
- R9: Codes 29 (register compare) and 30 (immediate compare) drive `wen_o`=0 and `res_o`=0. They set `zero_o` to 1 exactly when `reg_i` equals `opnd_i`.
- R10: For every listed code other than compare, `wen_o`=1 and `zero_o` is 1 exactly when the result is 0.
- R11: Any code not listed in R2 to R9, including 9, gives `res_o`=0 and `wen_o`=0. It leaves `zero_o` at its previous value.
- R12: All outputs reflect the inputs sampled at the previous rising edge. The memory and immediate forms of one operation give identical outputs for identical operand values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 6 | Operation code |
| reg_i | input | 8 | Register operand (left-hand) |
| opnd_i | input | 8 | Second operand: memory word or immediate |
| res_o | output | 8 | Registered result |
| zero_o | output | 1 | Registered zero flag |
| wen_o | output | 1 | Registered register write-enable |

## Verification
The zero flag is the only state that lives across operations, so a flag that was captured wrongly stays invisible until a conditional consumer reads it. An unlisted code exposes it immediately, because it should hold the flag unchanged. The bench therefore places unlisted codes right after flag-setting operations.

A wrong decode shows up one cycle later as a wrong `res_o` or a spurious `wen_o`. Mixing up the divide-by-zero branch or the rotate fill only shows with the matching operand corners: a zero divisor, or bit 7 and bit 0 set. The bench applies those corners directly and compares every cycle against a behavioural model.

// File: rtl/rmalu_pkg.sv
package rmalu_pkg;

  localparam int OPW = 6;

  typedef enum logic [1:0] {U_ARITH, U_DIV, U_BIT} unit_e;

  typedef struct packed {
    logic       known;
    logic       wr;
    unit_e      unit;
    logic [2:0] sub;
  } dec_t;

  function automatic dec_t decode(input logic [OPW-1:0] op);
    dec_t d;
    d.known = 1'b1;
    d.wr    = 1'b1;
    d.unit  = U_ARITH;
    d.sub   = 3'd0;
    case (op)
      6'd7,  6'd8:  begin d.unit = U_ARITH; d.sub = 3'd0; end
      6'd10, 6'd11: begin d.unit = U_ARITH; d.sub = 3'd1; end
      6'd12, 6'd13: begin d.unit = U_ARITH; d.sub = 3'd2; end
      6'd14, 6'd15: begin d.unit = U_DIV;   d.sub = 3'd0; end
      6'd16, 6'd17: begin d.unit = U_DIV;   d.sub = 3'd1; end
      6'd21: begin d.unit = U_BIT; d.sub = 3'd0; end
      6'd22: begin d.unit = U_BIT; d.sub = 3'd1; end
      6'd23: begin d.unit = U_BIT; d.sub = 3'd2; end
      6'd24: begin d.unit = U_BIT; d.sub = 3'd3; end
      6'd25: begin d.unit = U_BIT; d.sub = 3'd4; end
      6'd26: begin d.unit = U_BIT; d.sub = 3'd5; end
      6'd27: begin d.unit = U_BIT; d.sub = 3'd6; end
      6'd28: begin d.unit = U_BIT; d.sub = 3'd7; end
      6'd29, 6'd30: begin d.unit = U_ARITH; d.sub = 3'd1; d.wr = 1'b0; end
      default: begin d.known = 1'b0; d.wr = 1'b0; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rmalu_arith.sv
module rmalu_arith #(
  parameter int W = 8
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int PW = 2 * W;
  logic [PW-1:0] prod;

  always_comb begin
    prod = PW'(a) * PW'(b);
    case (sel)
      2'd0:    y = a + b;
      2'd1:    y = a - b;
      default: y = prod[W-1:0];
    endcase
  end
endmodule

// File: rtl/rmalu_div.sv
module rmalu_div #(
  parameter int W = 8
) (
  input  logic         rem_sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};
  logic b_zero;

  always_comb begin
    b_zero = (b == '0);
    if (b_zero)
      y = rem_sel ? a : ALL1;
    else
      y = rem_sel ? (a % b) : (a / b);
  end
endmodule

// File: rtl/rmalu_bitops.sv
module rmalu_bitops #(
  parameter int W = 8
) (
  input  logic [2:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (sel)
      3'd0: y = a & b;
      3'd1: y = a | b;
      3'd2: y = a ^ b;
      3'd3: y = ~a;
      3'd4: y = {a[W-2:0], 1'b0};
      3'd5: y = {1'b0, a[W-1:1]};
      3'd6: y = {a[W-2:0], a[W-1]};
      default: y = {a[0], a[W-1:1]};
    endcase
  end
endmodule

// File: rtl/rmalu.sv
module rmalu
  import rmalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   reg_i,
  input  logic [W-1:0]   opnd_i,
  output logic [W-1:0]   res_o,
  output logic           zero_o,
  output logic           wen_o
);
  dec_t         dec;
  logic [W-1:0] y_arith, y_div, y_bit, val, res_d;
  logic         zero_d;

  always_comb dec = decode(op_i);

  rmalu_arith #(.W(W)) u_arith (
    .sel(dec.sub[1:0]), .a(reg_i), .b(opnd_i), .y(y_arith));

  rmalu_div #(.W(W)) u_div (
    .rem_sel(dec.sub[0]), .a(reg_i), .b(opnd_i), .y(y_div));

  rmalu_bitops #(.W(W)) u_bit (
    .sel(dec.sub), .a(reg_i), .b(opnd_i), .y(y_bit));

  always_comb begin
    case (dec.unit)
      U_ARITH: val = y_arith;
      U_DIV:   val = y_div;
      default: val = y_bit;
    endcase
    res_d  = dec.wr ? val : '0;
    zero_d = dec.known ? (val == '0) : zero_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      zero_o <= 1'b0;
      wen_o  <= 1'b0;
    end else begin
      res_o  <= res_d;
      zero_o <= zero_d;
      wen_o  <= dec.wr;
    end
  end
endmodule

// File: rtl/rmalu_chk.sv
module rmalu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [5:0]   op_i,
  input logic [W-1:0] reg_i,
  input logic [W-1:0] opnd_i,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic         wen_o
);
  logic warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 1'b0;
    else     warm <= 1'b1;
  end

  logic listed;
  always_comb listed = (op_i >= 6'd7 && op_i <= 6'd30 && op_i != 6'd9 &&
                        !(op_i >= 6'd18 && op_i <= 6'd20));

  // R9
  a_r9_cmp_quiet: assert property (@(posedge clk) disable iff (rst)
    (warm && ($past(op_i) == 6'd29 || $past(op_i) == 6'd30)) |->
      (!wen_o && res_o == '0 && zero_o == ($past(reg_i) == $past(opnd_i))));

  // R10
  a_r10_zero_match: assert property (@(posedge clk) disable iff (rst)
    wen_o |-> (zero_o == (res_o == '0)));

  // R11
  a_r11_unlisted_hold: assert property (@(posedge clk) disable iff (rst)
    (warm && !$past(listed)) |->
      (!wen_o && res_o == '0 && zero_o == $past(zero_o)));

  // R6
  a_r6_div_zero: assert property (@(posedge clk) disable iff (rst)
    (warm && ($past(op_i) == 6'd14 || $past(op_i) == 6'd15) && $past(opnd_i) == '0)
      |-> (res_o == {W{1'b1}}));

  // R8
  a_r8_rol: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(op_i) == 6'd27) |->
      (res_o == {$past(reg_i[W-2:0]), $past(reg_i[W-1])}));
endmodule

bind rmalu rmalu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_rmalu.sv
module tb_rmalu;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [5:0]   op_i = '0;
  logic [W-1:0] reg_i = '0, opnd_i = '0;
  logic [W-1:0] res_o;
  logic         zero_o, wen_o;

  int total = 0, bad = 0;
  int exp_z = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rmalu #(.W(W)) dut (.clk, .rst, .op_i, .reg_i, .opnd_i, .res_o, .zero_o, .wen_o);

  task automatic model(input int op, input int a, input int b,
                       output int r, output int w);
    int v;
    bit known = 1;
    w = 1;
    case (op)
      7, 8:   v = (a + b) & 255;
      10, 11: v = (a - b) & 255;
      12, 13: v = (a * b) & 255;
      14, 15: v = (b == 0) ? 255 : a / b;
      16, 17: v = (b == 0) ? a : a % b;
      21: v = a & b;
      22: v = a | b;
      23: v = a ^ b;
      24: v = (~a) & 255;
      25: v = (a << 1) & 255;
      26: v = a >> 1;
      27: v = ((a << 1) | (a >> 7)) & 255;
      28: v = (a >> 1) | ((a & 1) << 7);
      29, 30: begin v = (a - b) & 255; w = 0; end
      default: begin v = 0; w = 0; known = 0; end
    endcase
    r = w ? v : 0;
    if (known) exp_z = (v == 0);
  endtask

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run(input int op, input int a, input int b, input string tag);
    int er, ew;
    @(negedge clk);
    op_i = 6'(op); reg_i = W'(a); opnd_i = W'(b);
    model(op, a, b, er, ew);
    @(posedge clk); #1;
    check(tag, int'(res_o), er, $sformatf("res op=%0d a=%0d b=%0d", op, a, b));
    check(tag, int'(wen_o), ew, $sformatf("wen op=%0d", op));
    check(tag, int'(zero_o), exp_z, $sformatf("zero op=%0d", op));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op_i = 6'd7; reg_i = 8'd5; opnd_i = 8'd5;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(res_o), 0, "reset res");
    check("R1", int'(zero_o), 0, "reset zero");
    check("R1", int'(wen_o), 0, "reset wen");
    @(negedge clk); rst = 1'b0;

    run(7, 200, 100, "R2");  run(8, 255, 1, "R2");
    run(10, 3, 5, "R3");     run(11, 9, 9, "R3");
    run(12, 16, 16, "R4");   run(13, 15, 17, "R4");
    run(14, 200, 7, "R5");   run(16, 200, 7, "R5");
    run(17, 12, 4, "R5");
    run(14, 77, 0, "R6");    run(15, 0, 0, "R6");
    run(16, 77, 0, "R6");    run(17, 0, 0, "R6");
    run(21, 8'hF0, 8'h3C, "R7"); run(22, 8'h0F, 8'hA0, "R7");
    run(23, 8'h5A, 8'h5A, "R7"); run(24, 8'hFF, 8'h12, "R7");
    run(25, 8'h81, 8'hFF, "R8"); run(26, 8'h81, 8'hFF, "R8");
    run(27, 8'h81, 0, "R8");     run(28, 8'h81, 0, "R8");
    run(25, 8'h80, 0, "R8");
    run(29, 42, 42, "R9");   run(30, 42, 41, "R9");
    run(10, 6, 6, "R10");    run(9, 1, 2, "R11");
    run(0, 1, 2, "R11");     run(31, 5, 5, "R11");
    run(7, 1, 1, "R10");     run(63, 0, 0, "R11");
    run(18, 0, 0, "R11");
    run(12, 33, 9, "R12");   run(13, 33, 9, "R12");
    run(16, 250, 13, "R12"); run(17, 250, 13, "R12");

    for (int i = 0; i < 400; i++)
      run(int'($urandom_range(0, 40)), int'($urandom_range(0, 255)),
          (i % 7 == 0) ? 0 : int'($urandom_range(0, 255)), "R12");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule